// File: doc/BRIEF.md
# Multi-Mode Memory Channel Interleave Mapper

This block turns a CPU byte address into a pair of values: the memory channel that holds the word, and the word's address inside that channel. It is meant to sit in front of a memory controller with up to three channels. A quasi-static `mode` input selects one of several interleave schemes. Two of them are power-of-two schemes that only route bits. One divides the whole word address by three. One reduces only a three-bit group of the word address modulo three, so some slots are given up. The last is an unequal pattern in which channel 0 holds twice as much memory as channels 1 and 2.

A request arrives on a valid/ready handshake. The mapped result appears one cycle later in a single output register, which also uses valid/ready. Back-pressure on the output stalls the input. The mapping is purely combinational between the input and that register. The exact divide-by-three uses a bit-serial chain that passes the remainder from one bit to the next.

Top module: `ilv_mapper`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `out_valid` is low and `in_ready` is high.
- R2: A request taken on a clock edge (`in_valid` and `in_ready` both high) shows up on `out_valid`/`out_chan`/`out_caddr` right after that edge. `in_ready` is high exactly when the output register is empty or is being taken (`!out_valid || out_ready`). A stalled output keeps its value.
- R3: Byte-address bits [2:0] never affect the result. The word address is `in_addr[ADDR_W-1:3]`, written w below.
- R4: Mode 0 (two-way): `out_chan` = w mod 2 and `out_caddr` = w >> 1.
- R5: Mode 1 (four-way): `out_chan` = w mod 4 and `out_caddr` = w >> 2.
- R6: Mode 2 (full three-way): `out_chan` = w mod 3 and `out_caddr` = w / 3, over the whole word address.
- R7: Mode 3 (grouped three-way): take k = w mod 8. Then `out_chan` = k mod 3 and `out_caddr` = (w >> 3)*3 + k/3, so eight consecutive words visit channels 0,1,2,0,1,2,0,1.
- R8: In mode 3, channel 2 never receives an address whose value mod 3 equals 2. That is the skipped slot.
- R9: Mode 4 (asymmetric): w mod 4 values 0,1,2,3 go to channels 0,1,0,2. Channel 0 gets (w >> 2)*2 + w[1]. Channels 1 and 2 get w >> 2.
- R10: Mode codes 5, 6 and 7 behave exactly as mode 0.
- R11: Within one mode, distinct word addresses never map to the same (channel, channel address) pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Interleave scheme; change only while nothing is in flight |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | ADDR_W | CPU byte address |
| out_valid | output | 1 | Mapped result present |
| out_ready | input | 1 | Downstream takes the result |
| out_chan | output | 2 | Channel index |
| out_caddr | output | ADDR_W-3 | Word address within the channel |

## Verification
Every mapped result is due on the clock edge after its request is taken. `in_ready` and `out_valid` respond in the same cycle to the state of the output register. A queue-based reference model, built from integer division and modulo, follows this timing. At each falling edge it compares `out_valid` against whether its queue holds an entry, and it compares the data against the queue head. Because the comparison repeats on every cycle of a stall, it also shows that the held value does not change. Back-pressure is random, and each mode runs sequential, random and all-ones addresses, with a duplicate check on the sequential run.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [2:0] {
    IM_TWO  = 3'd0,
    IM_FOUR = 3'd1,
    IM_MOD3 = 3'd2,
    IM_GRP3 = 3'd3,
    IM_ASYM = 3'd4
  } ilv_mode_e;

  localparam int unsigned CHAN_W = 2;
  localparam int unsigned BYTE_OFS_W = 3;

endpackage

// File: rtl/ilv_div3.sv
module ilv_div3 #(
  parameter int unsigned W = 29
) (
  input  logic [W-1:0] num,
  output logic [W-1:0] quo,
  output logic [1:0]   rem
);

  logic [1:0] rc [0:W];

  assign rc[W] = 2'b00;

  for (genvar j = W - 1; j >= 0; j--) begin : g_stage
    logic [2:0] t;
    assign t      = {rc[j+1], num[j]};
    assign quo[j] = (t >= 3'd3);
    assign rc[j]  = quo[j] ? (t[1:0] + 2'd1) : t[1:0];
  end

  assign rem = rc[0];

endmodule

// File: rtl/ilv_lane_map.sv
module ilv_lane_map
  import ilv_pkg::*;
#(
  parameter int unsigned WA_W = 29
) (
  input  logic [2:0]        mode,
  input  logic [WA_W-1:0]   wa,
  output logic [CHAN_W-1:0] chan,
  output logic [WA_W-1:0]   caddr
);

  logic [WA_W-1:0] d3_quo;
  logic [1:0]      d3_rem;

  ilv_div3 #(.W(WA_W)) u_div3 (
    .num (wa),
    .quo (d3_quo),
    .rem (d3_rem)
  );

  logic [1:0]      grp_chan;
  logic [1:0]      grp_sub;
  logic [WA_W-1:0] grp_addr;

  always_comb begin
    case (wa[2:0])
      3'd0: begin grp_chan = 2'd0; grp_sub = 2'd0; end
      3'd1: begin grp_chan = 2'd1; grp_sub = 2'd0; end
      3'd2: begin grp_chan = 2'd2; grp_sub = 2'd0; end
      3'd3: begin grp_chan = 2'd0; grp_sub = 2'd1; end
      3'd4: begin grp_chan = 2'd1; grp_sub = 2'd1; end
      3'd5: begin grp_chan = 2'd2; grp_sub = 2'd1; end
      3'd6: begin grp_chan = 2'd0; grp_sub = 2'd2; end
      default: begin grp_chan = 2'd1; grp_sub = 2'd2; end
    endcase
  end

  assign grp_addr = {2'b00, wa[WA_W-1:3], 1'b0}
                  + {3'b000, wa[WA_W-1:3]}
                  + {{(WA_W-2){1'b0}}, grp_sub};

  logic [1:0]      asym_chan;
  logic [WA_W-1:0] asym_addr;

  always_comb begin
    case (wa[1:0])
      2'd0, 2'd2: begin
        asym_chan = 2'd0;
        asym_addr = {1'b0, wa[WA_W-1:2], wa[1]};
      end
      2'd1: begin
        asym_chan = 2'd1;
        asym_addr = {2'b00, wa[WA_W-1:2]};
      end
      default: begin
        asym_chan = 2'd2;
        asym_addr = {2'b00, wa[WA_W-1:2]};
      end
    endcase
  end

  always_comb begin
    case (ilv_mode_e'(mode))
      IM_FOUR: begin
        chan  = wa[1:0];
        caddr = {2'b00, wa[WA_W-1:2]};
      end
      IM_MOD3: begin
        chan  = d3_rem;
        caddr = d3_quo;
      end
      IM_GRP3: begin
        chan  = grp_chan;
        caddr = grp_addr;
      end
      IM_ASYM: begin
        chan  = asym_chan;
        caddr = asym_addr;
      end
      default: begin
        chan  = {1'b0, wa[0]};
        caddr = {1'b0, wa[WA_W-1:1]};
      end
    endcase
  end

endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage #(
  parameter int unsigned CH_W = 2,
  parameter int unsigned CA_W = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CH_W-1:0] d_chan,
  input  logic [CA_W-1:0] d_caddr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CH_W-1:0] out_chan,
  output logic [CA_W-1:0] out_caddr
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_chan  <= d_chan;
      out_caddr <= d_caddr;
    end
  end

endmodule

// File: rtl/ilv_mapper.sv
module ilv_mapper
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_chan,
  output logic [ADDR_W-4:0] out_caddr
);

  localparam int unsigned WA_W = ADDR_W - BYTE_OFS_W;

  logic [WA_W-1:0]   word_addr;
  logic [2:0]        unused_byte_ofs;
  logic [CHAN_W-1:0] map_chan;
  logic [WA_W-1:0]   map_caddr;

  assign word_addr       = in_addr[ADDR_W-1:BYTE_OFS_W];
  assign unused_byte_ofs = in_addr[BYTE_OFS_W-1:0];

  ilv_lane_map #(.WA_W(WA_W)) u_map (
    .mode  (mode),
    .wa    (word_addr),
    .chan  (map_chan),
    .caddr (map_caddr)
  );

  ilv_out_stage #(.CH_W(CHAN_W), .CA_W(WA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_chan    (map_chan),
    .d_caddr   (map_caddr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_caddr (out_caddr)
  );

endmodule

// File: rtl/ilv_mapper_chk.sv
module ilv_mapper_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_chan,
  input logic [ADDR_W-4:0] out_caddr
);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  a_r2_accept_to_out: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_caddr));

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R6, R7, R9: three-channel schemes never emit index 3
  a_r6_three_chan_range: assert property (@(posedge clk) disable iff (rst)
    out_valid && (mode == 3'd2 || mode == 3'd3 || mode == 3'd4) |-> out_chan != 2'd3);

  // R4, R10: two-way and unused codes emit only 0 or 1
  a_r4_two_chan_range: assert property (@(posedge clk) disable iff (rst)
    out_valid && (mode == 3'd0 || mode >= 3'd5) |-> out_chan <= 2'd1);

  a_r8_skip_slot: assert property (@(posedge clk) disable iff (rst)
    out_valid && mode == 3'd3 && out_chan == 2'd2 |-> (out_caddr % 3) != 2);

endmodule

bind ilv_mapper ilv_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_chan  (out_chan),
  .out_caddr (out_caddr)
);

// File: tb/sim_ilv_mapper.sv
`timescale 1ns/1ps
module sim_ilv_mapper;

  localparam int ADDR_W = 32;

  typedef struct {
    int     ch;
    longint ca;
    string  tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        mode = 3'd0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [1:0]        out_chan;
  logic [ADDR_W-4:0] out_caddr;

  int     errors = 0;
  int     checks = 0;
  int     cyc = 0;
  bit     mon_on = 1'b0;
  bit     acc_seen = 1'b0;
  bit     dup_on = 1'b0;
  exp_t   q[$];
  bit     seen[longint];

  always #2.5 clk = ~clk;

  ilv_mapper #(.ADDR_W(ADDR_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_caddr (out_caddr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t ref_map(input int m, input logic [ADDR_W-1:0] a);
    exp_t e;
    longint w = longint'(a >> 3);
    longint k;
    case (m)
      1: begin e.ch = int'(w % 4); e.ca = w / 4; end
      2: begin e.ch = int'(w % 3); e.ca = w / 3; end
      3: begin
        k = w % 8;
        e.ch = int'(k % 3);
        e.ca = (w / 8) * 3 + k / 3;
      end
      4: begin
        case (int'(w % 4))
          0: begin e.ch = 0; e.ca = (w / 4) * 2; end
          1: begin e.ch = 1; e.ca = w / 4; end
          2: begin e.ch = 0; e.ca = (w / 4) * 2 + 1; end
          default: begin e.ch = 2; e.ca = w / 4; end
        endcase
      end
      default: begin e.ch = int'(w % 2); e.ca = w / 2; end
    endcase
    e.tag = mode_tag(m);
    if (a[2:0] != 3'd0) e.tag = {e.tag, "/R3"};
    return e;
  endfunction

  // reference model, evaluated between edges
  always @(negedge clk) begin
    if (mon_on) begin
      longint key;
      chk(out_valid == (q.size() != 0), "R2 out_valid", longint'(out_valid), longint'(q.size() != 0));
      chk(in_ready == (!out_valid || out_ready), "R2 in_ready", longint'(in_ready),
          longint'(!out_valid || out_ready));
      if (out_valid && q.size() != 0) begin
        chk(int'(out_chan) == q[0].ch, {q[0].tag, " chan"}, longint'(out_chan), longint'(q[0].ch));
        chk(longint'(out_caddr) == q[0].ca, {q[0].tag, " caddr"}, longint'(out_caddr), q[0].ca);
      end
      if (out_valid && out_ready) begin
        if (mode == 3'd3 && out_chan == 2'd2)
          chk((longint'(out_caddr) % 3) != 2, "R8 skipped slot", longint'(out_caddr) % 3, 0);
        if (dup_on) begin
          key = (longint'(out_chan) << 40) | longint'(out_caddr);
          chk(!seen.exists(key), "R11 collision", 1, 0);
          seen[key] = 1'b1;
        end
        if (q.size() != 0) void'(q.pop_front());
      end
      if (in_valid && in_ready) begin
        q.push_back(ref_map(int'(mode), in_addr));
        acc_seen = 1'b1;
      end else begin
        acc_seen = 1'b0;
      end
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a);
    bit take;
    in_valid = 1'b1;
    in_addr  = a;
    forever begin
      @(posedge clk);
      take = acc_seen;
      #1;
      out_ready = ($urandom % 4) != 0;
      if (take) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (3) begin
      @(posedge clk);
      #1;
      out_ready = 1'b1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs during reset
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", longint'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    mon_on = 1'b1;

    for (int m = 0; m < 8; m++) begin
      drain();
      mode = 3'(m);
      seen.delete();
      dup_on = 1'b1;
      for (int w = 0; w < 96; w++) send({w[28:0], 3'($urandom)});
      drain();
      dup_on = 1'b0;
      for (int r = 0; r < 40; r++) send($urandom);
      send('1);
      send(32'h0000_0007);
      drain();
    end

    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule